// File: doc/BRIEF.md
# Configuration Window Address Sequencer

This block turns a configuration request, given as a bus number, a device/function number and a register offset, into the offset inside a 16 MB memory-mapped configuration window and into the 16-bit map value that steers that window onto the bus. Requests for bus 0 become type 0 cycles: the one-hot device select sits in the window address for low slots and moves into the upper-address field of the map value for high slots. Requests for any other bus become type 1 cycles, and the map value then passes the two low address bits through from the local side.

After a legal request is accepted, a sequencer drives a short stream of register writes to the bridge's window registers. It first widens window 0 so that it hides window 1, then points window 1 at configuration space. It then issues one access strobe into the window, puts window 1 back to prefetchable memory and only then shrinks window 0 again. Requests with any field above 255 are flagged and never start a sequence.

Top module: `cfg_window_seq`

## Requirements
- R1: A request with bus number 0 is a type 0 cycle (is_type1 = 0, map_val bits 3:0 = 4'b1010); any other bus number is a type 1 cycle (is_type1 = 1, map_val = 16'h000B). Bits 3:1 hold the configuration cycle code 3'b101 in both cases, and bit 0 is the low-address pass-through bit.
- R2: For type 0, win_addr bits 10:8 hold the function number (devfn bits 2:0), and for slot = devfn bits 7:3 in 0..12 exactly one select bit is set at win_addr bit slot+11.
- R3: For type 0 with slot 13..20, win_addr carries no select bit and map_val bit slot-5 is set; for slot 21..31 neither win_addr nor map_val carries a select bit (map_val = 16'h000A).
- R4: For type 1, win_addr bits 23:16 hold the bus number and bits 15:8 hold devfn.
- R5: The register offset is added to the generated address and occupies win_addr bits 7:0 in both cycle types, including its two low bits.
- R6: A start seen while idle with bus_num, devfn or reg_off above 255 sets illegal to 1, keeps busy low and leaves win_addr, map_val and is_type1 unchanged; the next accepted legal start clears illegal.
- R7: The cycle after a legal start, three window writes follow on consecutive cycles, with wr_sel coding 0 = window 0 base, 1 = window 1 base, 2 = window 1 map: window 0 base 32'h4000_0091 (512 MB), window 1 base 32'h6100_0041 (16 MB, configuration area), window 1 map {16'h0000, map_val}. A base word is address bits 31:20 in bits 31:20, size code in bits 7:4 (4 = 16 MB, 8 = 256 MB, 9 = 512 MB), prefetch in bit 3 and enable in bit 0.
- R8: The next cycle raises acc_strobe for exactly one cycle with acc_addr = 32'h6100_0000 + win_addr; acc_addr is 0 whenever acc_strobe is low.
- R9: Three closing writes follow on consecutive cycles: window 1 base 32'h5000_0089 (256 MB, prefetchable), window 1 map 32'h0000_100C (bus address 0x1000_0000, memory-read-multiple code 3'b110), then window 0 base 32'h4000_0081 (256 MB). wr_data is 0 whenever wr_en is low.
- R10: busy is high for the eight cycles from the cycle after an accepted start through the done cycle; done is high in the last of them only; a start while busy is ignored.
- R11: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| bus_num | input | 9 | Bus number (values above 255 are illegal) |
| devfn | input | 9 | Device in bits 7:3, function in bits 2:0 |
| reg_off | input | 9 | Configuration register offset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of a sequence |
| illegal | output | 1 | Last taken request was out of range |
| is_type1 | output | 1 | Captured request is a type 1 cycle |
| win_addr | output | 24 | Offset inside the configuration window |
| map_val | output | 16 | Map value programmed into window 1 |
| wr_en | output | 1 | Window register write strobe |
| wr_sel | output | 2 | Window register being written |
| wr_data | output | 32 | Window register write data |
| acc_strobe | output | 1 | Configuration access strobe |
| acc_addr | output | 32 | Local address of the configuration access |

## Verification
The bench aims at the slot boundaries 12/13 and 20/21 on bus 0, where a wrong split would put a select bit at the wrong address or drop or misplace it in the map value, and at bus 255 with devfn and offset 255, where a truncated field would corrupt the type 1 address. It sends each out-of-range field on its own to catch a range check that looks at only one input or that still starts a sequence, and raises start mid-sequence with different fields to catch a design that restarts or recaptures. The order of the six window writes is compared every cycle, so shrinking window 0 before window 1 is restored shows up as a mismatch.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OPEN   = 3'd1,
    ST_ACCESS = 3'd2,
    ST_CLOSE  = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    SEL_W0_BASE = 2'd0,
    SEL_W1_BASE = 2'd1,
    SEL_W1_MAP  = 2'd2
  } win_sel_t;

  localparam logic [3:0] SZ_16M  = 4'd4;
  localparam logic [3:0] SZ_256M = 4'd8;
  localparam logic [3:0] SZ_512M = 4'd9;

  localparam logic [2:0] KIND_CFG     = 3'b101;
  localparam logic [2:0] KIND_MEMMULT = 3'b110;

  // Fields of a window base word: local address, size, prefetch, enable.
  function automatic logic [31:0] base_word(input logic [31:0] local_addr,
                                            input logic [3:0]  size_code,
                                            input logic        prefetch);
    return {local_addr[31:20], 12'd0, size_code, prefetch, 2'b00, 1'b1};
  endfunction

  // Map word for a memory window: bus address bits 31:20 and cycle kind.
  function automatic logic [15:0] map_word(input logic [31:0] bus_addr,
                                           input logic [2:0]  kind);
    return {bus_addr[31:20], kind, 1'b0};
  endfunction

endpackage

// File: rtl/cfgwin_addr_calc.sv
module cfgwin_addr_calc
  import cfgwin_pkg::*;
#(
  parameter int REQ_W  = 9,
  parameter int WIN_AW = 24,
  parameter int MAP_W  = 16
) (
  input  logic [REQ_W-1:0]  bus_num,
  input  logic [REQ_W-1:0]  devfn,
  input  logic [REQ_W-1:0]  reg_off,
  output logic              legal,
  output logic              type1,
  output logic [WIN_AW-1:0] addr,
  output logic [MAP_W-1:0]  map
);

  localparam int FLD_W     = 8;
  localparam int SEL_LSB   = 11;
  localparam int LOW_SLOTS = 12;
  localparam int MAP_SHIFT = 5;
  localparam int MAP_LSB   = LOW_SLOTS + 1 - MAP_SHIFT;

  logic [4:0]        slot;
  logic [2:0]        func;
  logic [WIN_AW-1:0] sel_addr;
  logic [MAP_W-1:0]  sel_map;

  generate
    if (REQ_W > FLD_W) begin : g_range_chk
      assign legal = ~|{bus_num[REQ_W-1:FLD_W], devfn[REQ_W-1:FLD_W],
                        reg_off[REQ_W-1:FLD_W]};
    end else begin : g_no_range_chk
      assign legal = 1'b1;
    end
  endgenerate

  assign slot  = devfn[7:3];
  assign func  = devfn[2:0];
  assign type1 = |bus_num[FLD_W-1:0];

  // One-hot select: low slots in the address, high slots in the map word.
  always_comb begin
    sel_addr = '0;
    for (int b = SEL_LSB; b <= SEL_LSB + LOW_SLOTS; b++) begin
      if (int'(slot) == b - SEL_LSB) sel_addr[b] = 1'b1;
    end
  end

  always_comb begin
    sel_map = '0;
    for (int b = MAP_LSB; b < MAP_W; b++) begin
      if (int'(slot) == b + MAP_SHIFT) sel_map[b] = 1'b1;
    end
  end

  always_comb begin
    if (type1) begin
      addr = WIN_AW'({bus_num[FLD_W-1:0], devfn[FLD_W-1:0], 8'h00})
           + WIN_AW'(reg_off[FLD_W-1:0]);
      map  = MAP_W'({KIND_CFG, 1'b1});
    end else begin
      addr = sel_addr + WIN_AW'({func, 8'h00}) + WIN_AW'(reg_off[FLD_W-1:0]);
      map  = sel_map | MAP_W'({KIND_CFG, 1'b0});
    end
  end

endmodule

// File: rtl/cfgwin_req_reg.sv
module cfgwin_req_reg #(
  parameter int WIN_AW = 24,
  parameter int MAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              legal,
  input  logic              type1_in,
  input  logic [WIN_AW-1:0] addr_in,
  input  logic [MAP_W-1:0]  map_in,
  output logic              illegal,
  output logic              type1_q,
  output logic [WIN_AW-1:0] addr_q,
  output logic [MAP_W-1:0]  map_q
);

  logic load;
  assign load = take & legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type1_q <= 1'b0;
      addr_q  <= '0;
      map_q   <= '0;
    end else if (load) begin
      type1_q <= type1_in;
      addr_q  <= addr_in;
      map_q   <= map_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal <= 1'b0;
    end else if (take) begin
      illegal <= ~legal;
    end
  end

endmodule

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
  import cfgwin_pkg::*;
#(
  parameter int          WIN_AW    = 24,
  parameter int          MAP_W     = 16,
  parameter logic [31:0] NP_LOCAL  = 32'h4000_0000,
  parameter logic [31:0] PF_LOCAL  = 32'h5000_0000,
  parameter logic [31:0] PF_BUS    = 32'h1000_0000,
  parameter logic [31:0] CFG_LOCAL = 32'h6100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [WIN_AW-1:0] addr_q,
  input  logic [MAP_W-1:0]  map_q,
  output logic              idle,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic [1:0]        wr_sel,
  output logic [31:0]       wr_data,
  output logic              acc_strobe,
  output logic [31:0]       acc_addr
);

  localparam int STEPS  = 3;
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = ST_OPEN;
          step_d  = '0;
        end
      end
      ST_OPEN: begin
        if (step_q == LAST_STEP) begin
          state_d = ST_ACCESS;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_ACCESS: state_d = ST_CLOSE;
      ST_CLOSE: begin
        if (step_q == LAST_STEP) begin
          state_d = ST_DONE;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign step_en = (state_q != ST_IDLE) || launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else if (step_en) begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_sel  = SEL_W0_BASE;
    wr_data = '0;
    if (state_q == ST_OPEN) begin
      wr_en = 1'b1;
      unique case (step_q)
        2'd0: begin
          wr_sel  = SEL_W0_BASE;
          wr_data = base_word(NP_LOCAL, SZ_512M, 1'b0);
        end
        2'd1: begin
          wr_sel  = SEL_W1_BASE;
          wr_data = base_word(CFG_LOCAL, SZ_16M, 1'b0);
        end
        default: begin
          wr_sel  = SEL_W1_MAP;
          wr_data = 32'(map_q);
        end
      endcase
    end else if (state_q == ST_CLOSE) begin
      wr_en = 1'b1;
      unique case (step_q)
        2'd0: begin
          wr_sel  = SEL_W1_BASE;
          wr_data = base_word(PF_LOCAL, SZ_256M, 1'b1);
        end
        2'd1: begin
          wr_sel  = SEL_W1_MAP;
          wr_data = 32'(map_word(PF_BUS, KIND_MEMMULT));
        end
        default: begin
          wr_sel  = SEL_W0_BASE;
          wr_data = base_word(NP_LOCAL, SZ_256M, 1'b0);
        end
      endcase
    end
  end

  assign idle       = (state_q == ST_IDLE);
  assign busy       = !idle;
  assign done       = (state_q == ST_DONE);
  assign acc_strobe = (state_q == ST_ACCESS);
  assign acc_addr   = acc_strobe ? (CFG_LOCAL + 32'(addr_q)) : 32'd0;

endmodule

// File: rtl/cfg_window_seq.sv
module cfg_window_seq #(
  parameter int          REQ_W     = 9,
  parameter int          WIN_AW    = 24,
  parameter int          MAP_W     = 16,
  parameter logic [31:0] NP_LOCAL  = 32'h4000_0000,
  parameter logic [31:0] PF_LOCAL  = 32'h5000_0000,
  parameter logic [31:0] PF_BUS    = 32'h1000_0000,
  parameter logic [31:0] CFG_LOCAL = 32'h6100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REQ_W-1:0]  bus_num,
  input  logic [REQ_W-1:0]  devfn,
  input  logic [REQ_W-1:0]  reg_off,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic              is_type1,
  output logic [WIN_AW-1:0] win_addr,
  output logic [MAP_W-1:0]  map_val,
  output logic              wr_en,
  output logic [1:0]        wr_sel,
  output logic [31:0]       wr_data,
  output logic              acc_strobe,
  output logic [31:0]       acc_addr
);

  logic              legal;
  logic              type1_c;
  logic [WIN_AW-1:0] addr_c;
  logic [MAP_W-1:0]  map_c;
  logic              idle;
  logic              take;

  assign take = start & idle;

  cfgwin_addr_calc #(
    .REQ_W (REQ_W),
    .WIN_AW(WIN_AW),
    .MAP_W (MAP_W)
  ) u_calc (
    .bus_num(bus_num),
    .devfn  (devfn),
    .reg_off(reg_off),
    .legal  (legal),
    .type1  (type1_c),
    .addr   (addr_c),
    .map    (map_c)
  );

  cfgwin_req_reg #(
    .WIN_AW(WIN_AW),
    .MAP_W (MAP_W)
  ) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .legal   (legal),
    .type1_in(type1_c),
    .addr_in (addr_c),
    .map_in  (map_c),
    .illegal (illegal),
    .type1_q (is_type1),
    .addr_q  (win_addr),
    .map_q   (map_val)
  );

  cfgwin_seq #(
    .WIN_AW   (WIN_AW),
    .MAP_W    (MAP_W),
    .NP_LOCAL (NP_LOCAL),
    .PF_LOCAL (PF_LOCAL),
    .PF_BUS   (PF_BUS),
    .CFG_LOCAL(CFG_LOCAL)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (take & legal),
    .addr_q    (win_addr),
    .map_q     (map_val),
    .idle      (idle),
    .busy      (busy),
    .done      (done),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .acc_strobe(acc_strobe),
    .acc_addr  (acc_addr)
  );

endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk #(
  parameter int WIN_AW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              is_type1,
  input logic              map_lsb,
  input logic [WIN_AW-1:0] win_addr,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              acc_strobe
);

  // R1: pass-through bit of the map value follows the cycle type
  p_type_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_type1 == map_lsb);

  // R6: a flagged request never runs a sequence
  p_illegal_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy);

  // R7: the first action of a sequence widens window 0
  p_open_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (wr_en && wr_sel == 2'd0));

  // R8: the access follows the window 1 map write and no write overlaps it
  p_access_after_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe |-> (!wr_en && $past(wr_en) && $past(wr_sel) == 2'd2));

  // R9: window 0 is shrunk as the very last write
  p_close_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && $past(wr_sel) == 2'd0 && !wr_en));

  // R10: the captured address holds while the sequence runs
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(win_addr));

  // R10: done ends the busy period
  p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

bind cfg_window_seq cfg_window_chk #(.WIN_AW(WIN_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .illegal   (illegal),
  .is_type1  (is_type1),
  .map_lsb   (map_val[0]),
  .win_addr  (win_addr),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .acc_strobe(acc_strobe)
);

// File: tb/sim_cfg_window_seq.sv
`timescale 1ns/1ps
module sim_cfg_window_seq;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [8:0]  bus_num;
  logic [8:0]  devfn;
  logic [8:0]  reg_off;
  logic        busy, done, illegal, is_type1, wr_en, acc_strobe;
  logic [23:0] win_addr;
  logic [15:0] map_val;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data, acc_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  cfg_window_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_num(bus_num),
    .devfn(devfn), .reg_off(reg_off), .busy(busy), .done(done),
    .illegal(illegal), .is_type1(is_type1), .win_addr(win_addr),
    .map_val(map_val), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .acc_strobe(acc_strobe), .acc_addr(acc_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model state
  int          m_phase;
  bit          m_illegal, m_t1;
  logic [23:0] m_addr;
  logic [15:0] m_map;

  task automatic predict(input int b, input int d, input int o,
                         output logic [23:0] a, output logic [15:0] m,
                         output bit t1);
    int slot;
    slot = d / 8;
    if (b == 0) begin
      t1 = 0;
      a  = 24'((d % 8) * 256 + o);
      m  = 16'h000A;
      if (slot <= 12) a = a + 24'(1 << (slot + 11));
      else if (slot <= 20) m = m | 16'(1 << (slot - 5));
    end else begin
      t1 = 1;
      a  = 24'(b * 65536 + d * 256 + o);
      m  = 16'h000B;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_illegal = 0; m_t1 = 0; m_addr = '0; m_map = '0;
    end else if (m_phase == 0) begin
      if (start) begin
        if (bus_num > 255 || devfn > 255 || reg_off > 255) begin
          m_illegal = 1;
        end else begin
          m_illegal = 0;
          predict(int'(bus_num), int'(devfn), int'(reg_off), m_addr, m_map, m_t1);
          m_phase = 1;
        end
      end
    end else begin
      m_phase = (m_phase == 8) ? 0 : m_phase + 1;
    end
  end

  task automatic cmp(input string what, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic        e_en, e_acc;
      logic [1:0]  e_sel;
      logic [31:0] e_data, e_aaddr;
      e_en = 0; e_sel = 0; e_data = 0; e_acc = 0; e_aaddr = 0;
      case (m_phase)
        1: begin e_en = 1; e_sel = 0; e_data = 32'h4000_0091; end
        2: begin e_en = 1; e_sel = 1; e_data = 32'h6100_0041; end
        3: begin e_en = 1; e_sel = 2; e_data = {16'h0, m_map}; end
        4: begin e_acc = 1; e_aaddr = 32'h6100_0000 + {8'h0, m_addr}; end
        5: begin e_en = 1; e_sel = 1; e_data = 32'h5000_0089; end
        6: begin e_en = 1; e_sel = 2; e_data = 32'h0000_100C; end
        7: begin e_en = 1; e_sel = 0; e_data = 32'h4000_0081; end
        default: ;
      endcase
      if (!rst_n) begin
        // R11: everything zero in reset
        cmp("outputs in reset", "R11",
            {busy, done, illegal, is_type1, wr_en, acc_strobe, wr_sel, map_val}, 32'd0);
        cmp("addr in reset", "R11", {wr_data | acc_addr | {8'h0, win_addr}}, 32'd0);
      end else begin
        cmp("busy", "R10", {31'd0, busy}, {31'd0, m_phase != 0});
        cmp("done", "R10", {31'd0, done}, {31'd0, m_phase == 8});
        cmp("illegal", "R6", {31'd0, illegal}, {31'd0, m_illegal});
        cmp("is_type1", "R1", {31'd0, is_type1}, {31'd0, m_t1});
        cmp("win_addr", "R2 R3 R4 R5", {8'h0, win_addr}, {8'h0, m_addr});
        cmp("map_val", "R1 R3", {16'h0, map_val}, {16'h0, m_map});
        cmp("wr_en", "R7 R9", {31'd0, wr_en}, {31'd0, e_en});
        cmp("wr_sel", "R7 R9", {30'd0, wr_sel}, {30'd0, e_sel});
        cmp("wr_data", "R7 R9", wr_data, e_data);
        cmp("acc_strobe", "R8", {31'd0, acc_strobe}, {31'd0, e_acc});
        cmp("acc_addr", "R8", acc_addr, e_aaddr);
      end
    end
  end

  task automatic request(input int b, input int d, input int o);
    @(negedge clk);
    bus_num = 9'(b); devfn = 9'(d); reg_off = 9'(o); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; bus_num = '0; devfn = '0; reg_off = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    request(0, 0, 0);             // R2 slot 0 -> address bit 11
    request(0, 12*8 + 7, 8'hFF);  // R2 R5 slot 12 -> bit 23, func 7, offset FF
    request(0, 13*8 + 2, 8'h13);  // R3 slot 13 -> map bit 8
    request(0, 20*8, 8'h04);      // R3 slot 20 -> map bit 15
    request(0, 21*8 + 1, 8'h08);  // R3 slot 21 -> no select anywhere
    request(0, 31*8 + 5, 8'h02);  // R3 slot 31
    request(1, 8'h5A, 8'h3C);     // R1 R4 type 1
    request(255, 255, 255);       // R4 R5 upper corners
    request(256, 0, 0);           // R6 bus out of range
    request(0, 3, 0);             // R6 cleared by legal start
    request(0, 256, 4);           // R6 devfn out of range
    request(2, 8, 300);           // R6 offset out of range
    // R10: start held during a sequence with other fields is ignored
    @(negedge clk);
    bus_num = 9'd3; devfn = 9'h11; reg_off = 9'h20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    bus_num = 9'd0; devfn = 9'h08; reg_off = 9'h00; start = 1'b1;
    @(negedge clk);
    bus_num = 9'd300;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    // back-to-back: start held high across the done cycle
    bus_num = 9'd0; devfn = 9'd40; reg_off = 9'd8; start = 1'b1;
    repeat (12) @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule